// File: doc/BRIEF.md
# Bus Error Watchdog and System Control Register

This block pairs an 8-bit system control register with a bus error watchdog. It is meant for a processor bus where each cycle ends when an acknowledge arrives. A start pulse marks the beginning of each bus cycle, and the watchdog then counts clocks until that cycle is acknowledged. When the timer is enabled and the count reaches its limit, the block records a timeout and raises a one-clock bus error. The timeout also covers accesses to unmapped address space that never get acknowledged.

Write-protect and privilege violations come from neighbouring logic as single-clock pulses. Each one is recorded as a sticky status bit. A bus error is signalled only while the timer enable bit is set; with the enable bit clear, the offending cycle is simply left unterminated. Software clears a status bit by writing a 1 to it.

A supervisor-only control bit locks the register against user-mode software. A refused access reads as zero, does not change the register, and counts as a privilege violation.

Top module: `busmon_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x1C and `bus_err` is low.
- R2: An allowed write loads bits 4 (timer enable), 3 (supervisor-only), 2 (map control) and 0 (narrow-width control) from `wr_data`. The new value reads back from the next clock.
- R3: The timer is enabled when bit 4 is 1. If a cycle started by `cyc_start` gets no `cyc_ack` for 128 clocks, bit 7 is set and `bus_err` is high in the clock after the 128th edge. Either an acknowledge or a new start restarts the count. While bit 4 is 0, no timeout occurs.
- R4: Status bits 7, 6 and 5 are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R5: A `wp_viol` pulse sets bit 6, and a `priv_viol` pulse sets bit 5. In either case `bus_err` goes high one clock later, but only when bit 4 is 1.
- R6: When bit 3 is 1 and `cpu_super` is 0, a register access is refused: a read returns 0x00, a write changes nothing, and bit 5 is set. When bit 3 is 0, user-mode accesses behave like supervisor accesses.
- R7: Bit 1 always reads 0 and ignores writes.
- R8: Each timeout gives a single one-clock `bus_err` pulse. After that the timer stays idle until the next `cyc_start`.
- R9: If a status bit is set by hardware and cleared by a write in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register address matched |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational; 0 when not reading or when the access is refused |
| cpu_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| cyc_start | input | 1 | Bus cycle start pulse |
| cyc_ack | input | 1 | Bus cycle acknowledge |
| wp_viol | input | 1 | Write-protect violation pulse |
| priv_viol | input | 1 | Privilege violation pulse |
| bus_err | output | 1 | Registered bus error pulse |

## Verification
Read data is combinational, so it is checked in the same cycle as the read strobe. A write or a status event takes effect at the next rising edge, and the bench confirms it with a read in the following cycle. `bus_err` is due one edge after a violation pulse, and the 128th edge after the start edge for a timeout. The bench samples it at the falling edge just after the edge where it is due, and also at the falling edge one cycle earlier to confirm it was still low. All inputs change only on falling edges, so each check looks at the result of a known, counted number of rising edges.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
   localparam int REG_W = 8;
   // bit positions inside the control register
   localparam int B_TMO = 7;
   localparam int B_WPV = 6;
   localparam int B_PRV = 5;
   localparam int B_TEN = 4;
   localparam int B_SUP = 3;
   localparam int B_MAP = 2;
   localparam int B_RSV = 1;
   localparam int B_W8  = 0;
   typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/busmon_timer.sv
module busmon_timer #(
   parameter int LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start,
   input  logic ack,
   output logic expire
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic          active_q;
   logic [CW-1:0] cnt_q;

   assign expire = active_q && en && !ack && !start && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (ack || expire) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q && en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/busmon_access.sv
module busmon_access (
   input  logic reg_sel,
   input  logic reg_rd,
   input  logic reg_wr,
   input  logic cpu_super,
   input  logic sup_only,
   output logic allow_rd,
   output logic allow_wr,
   output logic refuse
);
   logic locked;
   assign locked   = sup_only && !cpu_super;
   assign allow_rd = reg_sel && reg_rd && !locked;
   assign allow_wr = reg_sel && reg_wr && !locked;
   assign refuse   = reg_sel && (reg_rd || reg_wr) && locked;
endmodule

// File: rtl/busmon_stickybit.sv
module busmon_stickybit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/busmon_ctrl_reg.sv
module busmon_ctrl_reg
   import busmon_pkg::*;
#(
   parameter int         TMO_CYCLES = 128,
   parameter logic [7:0] RESET_VAL  = 8'h1C,
   parameter logic [7:0] STAT_MASK  = 8'((1 << B_TMO) | (1 << B_WPV) | (1 << B_PRV)),
   parameter logic [7:0] CTL_MASK   = 8'((1 << B_TEN) | (1 << B_SUP) | (1 << B_MAP) | (1 << B_W8))
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_sel,
   input  logic       reg_rd,
   input  logic       reg_wr,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       cpu_super,
   input  logic       cyc_start,
   input  logic       cyc_ack,
   input  logic       wp_viol,
   input  logic       priv_viol,
   output logic       bus_err
);
   localparam logic [7:0] LIVE_MASK = STAT_MASK | CTL_MASK;

   if (TMO_CYCLES < 2) begin : g_bad_limit
      $error("TMO_CYCLES must be at least 2");
   end
   if ((STAT_MASK & CTL_MASK) != 8'h00) begin : g_bad_overlap
      $error("status and control masks overlap");
   end
   if (LIVE_MASK[B_RSV] != 1'b0) begin : g_bad_rsv
      $error("reserved bit must stay unimplemented");
   end
   if ((RESET_VAL & ~LIVE_MASK) != 8'h00) begin : g_bad_reset
      $error("reset value sets an unimplemented bit");
   end

   reg_t reg_q;
   reg_t set_vec;
   logic allow_rd, allow_wr, refuse;
   logic tmo_evt, priv_evt, bus_err_q;

   busmon_access u_access (
      .reg_sel  (reg_sel),
      .reg_rd   (reg_rd),
      .reg_wr   (reg_wr),
      .cpu_super(cpu_super),
      .sup_only (reg_q[B_SUP]),
      .allow_rd (allow_rd),
      .allow_wr (allow_wr),
      .refuse   (refuse)
   );

   busmon_timer #(.LIMIT(TMO_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (reg_q[B_TEN]),
      .start (cyc_start),
      .ack   (cyc_ack),
      .expire(tmo_evt)
   );

   assign priv_evt = priv_viol || refuse;

   always_comb begin
      set_vec        = '0;
      set_vec[B_TMO] = tmo_evt;
      set_vec[B_WPV] = wp_viol;
      set_vec[B_PRV] = priv_evt;
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (STAT_MASK[i]) begin : g_stat
         busmon_stickybit #(.RST_VAL(RESET_VAL[i])) u_sb (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_vec[i]),
            .clr  (allow_wr && wr_data[i]),
            .q    (reg_q[i])
         );
      end else if (CTL_MASK[i]) begin : g_ctl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        reg_q[i] <= RESET_VAL[i];
            else if (allow_wr) reg_q[i] <= wr_data[i];
         end
      end else begin : g_rsv
         assign reg_q[i] = 1'b0;
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~LIVE_MASK) ^ ^(set_vec & ~STAT_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_err_q <= 1'b0;
      else        bus_err_q <= tmo_evt || (reg_q[B_TEN] && (wp_viol || priv_evt));
   end

   assign bus_err = bus_err_q;
   assign rd_data = allow_rd ? reg_q : '0;
endmodule

// File: rtl/busmon_ctrl_reg_chk.sv
module busmon_ctrl_reg_chk
   import busmon_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reg_sel,
   input logic       reg_rd,
   input logic       reg_wr,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       cpu_super,
   input logic       wp_viol,
   input logic       bus_err,
   input logic [7:0] reg_q
);
   logic locked, wr_ok;
   assign locked = reg_q[B_SUP] && !cpu_super;
   assign wr_ok  = reg_sel && reg_wr && !locked;

   logic unused_chk;
   assign unused_chk = ^{reg_q[B_MAP], reg_q[B_RSV], reg_q[B_W8], wr_data[5:0], wr_data[7]};

   p_refused_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_rd && locked) |-> (rd_data == 8'h00));

   p_refused_sets_prv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && (reg_rd || reg_wr) && locked) |=> reg_q[B_PRV]);

   p_wp_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wp_viol |=> reg_q[B_WPV]);

   p_err_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(reg_q[B_TEN]));

   p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_data[B_WPV] && !wp_viol) |=> !reg_q[B_WPV]);

   p_tmo_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_q[B_TMO]) |-> bus_err);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_viol && wr_ok && wr_data[B_WPV]) |=> reg_q[B_WPV]);
endmodule

bind busmon_ctrl_reg busmon_ctrl_reg_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_sel  (reg_sel),
   .reg_rd   (reg_rd),
   .reg_wr   (reg_wr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .cpu_super(cpu_super),
   .wp_viol  (wp_viol),
   .bus_err  (bus_err),
   .reg_q    (reg_q)
);

// File: tb/busmon_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module busmon_ctrl_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       cpu_super = 1'b1;
   logic       cyc_start = 1'b0, cyc_ack = 1'b0;
   logic       wp_viol = 1'b0, priv_viol = 1'b0;
   logic       bus_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   busmon_ctrl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data),
      .cpu_super(cpu_super), .cyc_start(cyc_start), .cyc_ack(cyc_ack),
      .wp_viol(wp_viol), .priv_viol(priv_viol), .bus_err(bus_err)
   );

   // {do_write, write_super, write_data, read_super, expected}
   localparam int NV = 9;
   localparam logic [18:0] VEC [NV] = '{
      {1'b0, 1'b1, 8'h00, 1'b1, 8'h1C},  // R1 reset value
      {1'b1, 1'b1, 8'hFF, 1'b1, 8'h1D},  // R2 R7 control load, bit 1 stays 0
      {1'b1, 1'b0, 8'h00, 1'b1, 8'h3D},  // R6 user write refused, bit 5 set
      {1'b0, 1'b1, 8'h00, 1'b0, 8'h00},  // R6 user read refused reads 0
      {1'b1, 1'b1, 8'h1D, 1'b1, 8'h3D},  // R4 zero write keeps bit 5
      {1'b1, 1'b1, 8'h3D, 1'b1, 8'h1D},  // R4 one write clears bit 5
      {1'b1, 1'b1, 8'h04, 1'b1, 8'h04},  // R2 enable and supervisor-only off
      {1'b1, 1'b0, 8'h15, 1'b0, 8'h15},  // R6 user access allowed when unlocked
      {1'b1, 1'b1, 8'h1C, 1'b1, 8'h1C}   // R2 restore
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic reg_write(input logic sup, input logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; cpu_super = sup; wr_data = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; cpu_super = 1'b1; wr_data = 8'h00;
   endtask

   task automatic reg_read(input logic sup, output logic [7:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_rd = 1'b1; cpu_super = sup;
      #1 d = rd_data;
      @(negedge clk);
      reg_sel = 1'b0; reg_rd = 1'b0; cpu_super = 1'b1;
   endtask

   task automatic idle_watch(input int n, output int hits);
      hits = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (bus_err) hits++;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] rv;
      int hits;
      #5;
      check("R1 rd_data in reset", rd_data, 8'h00);
      check("R1 bus_err in reset", {7'b0, bus_err}, 8'h00);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][18]) reg_write(VEC[i][17], VEC[i][16:9]);
         reg_read(VEC[i][8], rv);
         check($sformatf("R2/R4/R6/R7 vector %0d", i), rv, VEC[i][7:0]);
      end

      // R3 timeout at the 128th edge; R8 single pulse then idle
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      repeat (127) @(negedge clk);
      check("R3 no error at edge 127", {7'b0, bus_err}, 8'h00);
      @(negedge clk);
      check("R3 error at edge 128", {7'b0, bus_err}, 8'h01);
      @(negedge clk);
      check("R8 error lasts one clock", {7'b0, bus_err}, 8'h00);
      idle_watch(200, hits);
      check("R8 timer idle after timeout", 8'(hits), 8'h00);
      reg_read(1'b1, rv);
      check("R3 timeout status set", rv, 8'h9C);
      reg_write(1'b1, 8'h9C);
      reg_read(1'b1, rv);
      check("R4 timeout status cleared", rv, 8'h1C);

      // R3 acknowledge stops the count
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      repeat (100) @(negedge clk);
      cyc_ack = 1'b1;
      @(negedge clk); cyc_ack = 1'b0;
      idle_watch(60, hits);
      check("R3 ack prevents error", 8'(hits), 8'h00);
      reg_read(1'b1, rv);
      check("R3 ack leaves status clear", rv, 8'h1C);

      // R3 R5 timer disabled
      reg_write(1'b1, 8'h0C);
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      idle_watch(200, hits);
      check("R3 no timeout while disabled", 8'(hits), 8'h00);
      @(negedge clk); wp_viol = 1'b1;
      @(negedge clk); wp_viol = 1'b0;
      check("R5 no error while disabled", {7'b0, bus_err}, 8'h00);
      reg_read(1'b1, rv);
      check("R5 wp status set while disabled", rv, 8'h4C);

      // R5 enabled write-protect violation
      reg_write(1'b1, 8'h5C);
      reg_read(1'b1, rv);
      check("R4 wp status cleared", rv, 8'h1C);
      @(negedge clk); wp_viol = 1'b1;
      @(negedge clk); wp_viol = 1'b0;
      check("R5 error after wp violation", {7'b0, bus_err}, 8'h01);
      reg_read(1'b1, rv);
      check("R5 wp status set", rv, 8'h5C);

      // R5 enabled privilege violation
      @(negedge clk); priv_viol = 1'b1;
      @(negedge clk); priv_viol = 1'b0;
      check("R5 error after privilege violation", {7'b0, bus_err}, 8'h01);
      reg_read(1'b1, rv);
      check("R5 priv status set", rv, 8'h7C);
      reg_write(1'b1, 8'h3C);
      reg_read(1'b1, rv);
      check("R4 priv status cleared", rv, 8'h5C);

      // R9 set beats clear in the same clock
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; wr_data = 8'h5C; wp_viol = 1'b1;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; wr_data = 8'h00; wp_viol = 1'b0;
      reg_read(1'b1, rv);
      check("R9 set wins over clear", rv, 8'h5C);
      reg_write(1'b1, 8'h5C);
      reg_read(1'b1, rv);
      check("R9 later clear takes effect", rv, 8'h1C);

      // R6 refused access raises error when enabled
      reg_write(1'b0, 8'h00);
      check("R6 refused write raises error", {7'b0, bus_err}, 8'h01);
      reg_read(1'b1, rv);
      check("R6 refused write ignored, bit 5 set", rv, 8'h3C);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule